// File: doc/BRIEF.md
# Memory SEC-DED Mode Controller

This block sits between a memory controller's data paths and a 64-bit memory array that stores eight check bits beside every word. A 32-bit mode register selects how the block treats that storage. It can leave it unused. It can generate check bits on writes and only report errors on reads. It can generate check bits and also repair single-bit errors on reads. In a diagnostic setting it writes a fixed check byte supplied by software, so that software can plant known faults in memory.

On a read, the block recomputes the check bits from the returned data and forms a syndrome. It classifies each read as clean, single-bit (correctable) or multiple-bit (uncorrectable). When correction is on, it flips the faulty data bit before the data goes back to the controller. Two sticky interrupt flags, each with its own enable bit, record single and multiple errors until a clear strobe removes them.

Top module: `ecc_mode_ctrl`

## Requirements
- R1: After reset the register reads 0x00000000, both interrupt flags are low, and the block behaves as in R3.
- R2: The register holds these fields: mode in bits 2:0, single-error interrupt enable in bit 3, multi-error interrupt enable in bit 4, and the diagnostic check byte in bits 15:8. Bits 7:5 and 31:16 always read 0, whatever was written to them.
- R3: With mode 000 or any of 100 through 111, `wr_check` is 0, `rd_data_out` equals `rd_data_in`, and neither error flag is raised.
- R4: With mode 001 or 010, `wr_check` is the extended Hamming code of `wr_data`. The data bits fill codeword positions 1..71 that are not powers of two, in ascending order. Check bit k (k<7) is the XOR of the data bits whose position has bit k set. Check bit 7 is the XOR of all data bits and check bits 6:0.
- R5: With mode 011, `wr_check` equals register bits 15:8.
- R6: A read with `rd_valid` high, odd overall parity and a syndrome of at most 71 raises `rd_err_single` in the same cycle. In mode 010, the data bit at that syndrome position is inverted on `rd_data_out`.
- R7: In modes 001 and 011, errors are flagged but `rd_data_out` always equals `rd_data_in`.
- R8: A single error in a check bit raises `rd_err_single` and leaves the data unchanged in every active mode.
- R9: In an active mode, `rd_err_multi` is raised for any of these reads: even overall parity with a nonzero syndrome, or odd overall parity with a syndrome above 71. The data is then left unchanged. The two error flags are never high together.
- R10: An error flag with `rd_valid` and its enable bit set raises the matching interrupt flag on the next clock edge. The interrupt flag then stays high.
- R11: A clear strobe drops its interrupt flag on the next edge. A new error arriving in the same cycle as the strobe wins, and the flag stays set.
- R12: An error whose enable bit is 0 never raises its interrupt flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_wdata | input | 32 | Register write value |
| cfg_rdata | output | 32 | Register read value |
| wr_data | input | 64 | Data word being written to memory |
| wr_check | output | 8 | Check byte to store with `wr_data` |
| rd_valid | input | 1 | Read data from memory is valid this cycle |
| rd_data_in | input | 64 | Data word read from memory |
| rd_check_in | input | 8 | Check byte read from memory |
| rd_data_out | output | 64 | Data returned to the controller, corrected if enabled |
| rd_err_single | output | 1 | Correctable error seen on this read |
| rd_err_multi | output | 1 | Uncorrectable error seen on this read |
| irq_clr_single | input | 1 | Clear strobe for the single-error flag |
| irq_clr_multi | input | 1 | Clear strobe for the multi-error flag |
| irq_single | output | 1 | Sticky single-error interrupt |
| irq_multi | output | 1 | Sticky multi-error interrupt |

## Verification
The write check byte, corrected read data and both error flags are combinational. The bench samples them one nanosecond after driving inputs at a falling edge, inside the same cycle. A register write becomes visible after the rising edge that captures it. The interrupt flags change on the rising edge after the read or clear strobe, so the bench samples them one nanosecond after that edge, once `rd_valid` has been dropped. To confirm that a flag is sticky, the bench samples it again after later clean reads.

// File: rtl/ecc_mode_pkg.sv
`timescale 1ns/1ps
package ecc_mode_pkg;
   typedef enum logic [2:0] {
      MODE_OFF     = 3'b000,
      MODE_DETECT  = 3'b001,
      MODE_CORRECT = 3'b010,
      MODE_DIAG    = 3'b011
   } ecc_mode_e;

   localparam int unsigned REG_W      = 32;
   localparam int unsigned MODE_LSB   = 0;
   localparam int unsigned SEN_BIT    = 3;
   localparam int unsigned MEN_BIT    = 4;
   localparam int unsigned DCHK_LSB   = 8;
endpackage

// File: rtl/ecc_cfg_reg.sv
`timescale 1ns/1ps
module ecc_cfg_reg
   import ecc_mode_pkg::*;
#(
   parameter int unsigned CHK_W = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 we,
   input  logic [REG_W-1:0]     wdata,
   output logic [REG_W-1:0]     rdata,
   output logic [2:0]           mode,
   output logic                 single_en,
   output logic                 multi_en,
   output logic [CHK_W-1:0]     diag_chk
);
   localparam int unsigned DCHK_MSB = DCHK_LSB + CHK_W - 1;

   if (DCHK_MSB >= REG_W) begin : g_bad_width
      $error("diagnostic check field does not fit the register");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode      <= '0;
         single_en <= 1'b0;
         multi_en  <= 1'b0;
         diag_chk  <= '0;
      end else if (we) begin
         mode      <= wdata[MODE_LSB +: 3];
         single_en <= wdata[SEN_BIT];
         multi_en  <= wdata[MEN_BIT];
         diag_chk  <= wdata[DCHK_LSB +: CHK_W];
      end
   end

   always_comb begin
      rdata                      = '0;
      rdata[MODE_LSB +: 3]       = mode;
      rdata[SEN_BIT]             = single_en;
      rdata[MEN_BIT]             = multi_en;
      rdata[DCHK_LSB +: CHK_W]   = diag_chk;
   end

   logic unused_bits;
   assign unused_bits = ^{wdata[REG_W-1:DCHK_MSB+1], wdata[DCHK_LSB-1:MEN_BIT+1]};
endmodule

// File: rtl/ecc_enc.sv
`timescale 1ns/1ps
module ecc_enc #(
   parameter int unsigned DATA_W = 64,
   parameter int unsigned CHK_W  = 8
) (
   input  logic [DATA_W-1:0] data,
   output logic [CHK_W-1:0]  check
);
   localparam int unsigned HAM_W = CHK_W - 1;

   if ((1 << HAM_W) < DATA_W + HAM_W + 1) begin : g_bad_code
      $error("too few check bits for the data width");
   end

   function automatic int unsigned pos_of(int unsigned idx);
      int unsigned n = 0;
      int unsigned r = 0;
      for (int unsigned q = 1; q < (1 << HAM_W); q++) begin
         if ((q & (q - 1)) != 0) begin
            if (n == idx) r = q;
            n++;
         end
      end
      return r;
   endfunction

   logic [HAM_W-1:0] ham;

   for (genvar k = 0; k < HAM_W; k++) begin : g_chk
      logic [DATA_W-1:0] sel;
      for (genvar j = 0; j < DATA_W; j++) begin : g_sel
         localparam int unsigned P = pos_of(j);
         assign sel[j] = ((P >> k) & 1) != 0 ? data[j] : 1'b0;
      end
      assign ham[k] = ^sel;
   end

   assign check = {(^data) ^ (^ham), ham};
endmodule

// File: rtl/ecc_dec.sv
`timescale 1ns/1ps
module ecc_dec #(
   parameter int unsigned DATA_W = 64,
   parameter int unsigned CHK_W  = 8
) (
   input  logic [DATA_W-1:0] data_in,
   input  logic [CHK_W-1:0]  check_in,
   input  logic [CHK_W-1:0]  recomputed,
   input  logic              fix_en,
   output logic [DATA_W-1:0] data_out,
   output logic              single,
   output logic              multi
);
   localparam int unsigned HAM_W   = CHK_W - 1;
   localparam int unsigned MAX_POS = DATA_W + HAM_W;

   function automatic int unsigned pos_of(int unsigned idx);
      int unsigned n = 0;
      int unsigned r = 0;
      for (int unsigned q = 1; q < (1 << HAM_W); q++) begin
         if ((q & (q - 1)) != 0) begin
            if (n == idx) r = q;
            n++;
         end
      end
      return r;
   endfunction

   logic [HAM_W-1:0]  syn;
   logic              par_odd;
   logic              in_range;
   logic [DATA_W-1:0] flip;

   assign syn      = recomputed[HAM_W-1:0] ^ check_in[HAM_W-1:0];
   assign par_odd  = (^data_in) ^ (^check_in);
   assign in_range = 32'(syn) <= MAX_POS;
   assign single   = par_odd && in_range;
   assign multi    = (par_odd && !in_range) || (!par_odd && (syn != '0));

   for (genvar j = 0; j < DATA_W; j++) begin : g_fix
      localparam int unsigned P = pos_of(j);
      assign flip[j] = fix_en && single && (32'(syn) == P);
   end

   assign data_out = data_in ^ flip;

   logic unused_top;
   assign unused_top = recomputed[CHK_W-1];

   always_comb begin
      assert ($onehot0(flip)); // R6
   end
endmodule

// File: rtl/ecc_irq_flag.sv
`timescale 1ns/1ps
module ecc_irq_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic hit,
   input  logic enable,
   input  logic clr,
   output logic flag
);
   always_ff @(posedge clk) begin
      if (!rst_n)              flag <= 1'b0;
      else if (hit && enable)  flag <= 1'b1;
      else if (clr)            flag <= 1'b0;
   end

   AST_FLAG_SET:  assert property (@(posedge clk) disable iff (!rst_n)
      hit && enable |=> flag); // R10
   AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      flag && !clr |=> flag); // R10
   AST_FLAG_CLR:  assert property (@(posedge clk) disable iff (!rst_n)
      clr && !(hit && enable) |=> !flag); // R11
   AST_FLAG_MASK: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag) |-> $past(enable)); // R12
endmodule

// File: rtl/ecc_mode_ctrl.sv
`timescale 1ns/1ps
module ecc_mode_ctrl
   import ecc_mode_pkg::*;
#(
   parameter int unsigned DATA_W = 64,
   parameter int unsigned CHK_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [31:0]       cfg_wdata,
   output logic [31:0]       cfg_rdata,
   input  logic [DATA_W-1:0] wr_data,
   output logic [CHK_W-1:0]  wr_check,
   input  logic              rd_valid,
   input  logic [DATA_W-1:0] rd_data_in,
   input  logic [CHK_W-1:0]  rd_check_in,
   output logic [DATA_W-1:0] rd_data_out,
   output logic              rd_err_single,
   output logic              rd_err_multi,
   input  logic              irq_clr_single,
   input  logic              irq_clr_multi,
   output logic              irq_single,
   output logic              irq_multi
);
   localparam int unsigned N_IRQ = 2;

   logic [2:0]        mode;
   logic              single_en, multi_en;
   logic [CHK_W-1:0]  diag_chk;
   logic [CHK_W-1:0]  gen_wr, gen_rd;
   logic              dec_single, dec_multi;
   logic [DATA_W-1:0] dec_data;
   logic              active, fixing;

   ecc_cfg_reg #(.CHK_W(CHK_W)) u_reg (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata),
      .rdata(cfg_rdata), .mode(mode), .single_en(single_en),
      .multi_en(multi_en), .diag_chk(diag_chk));

   ecc_enc #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_enc_wr (
      .data(wr_data), .check(gen_wr));

   ecc_enc #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_enc_rd (
      .data(rd_data_in), .check(gen_rd));

   assign active = (mode == MODE_DETECT) || (mode == MODE_CORRECT) || (mode == MODE_DIAG);
   assign fixing = (mode == MODE_CORRECT);

   ecc_dec #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_dec (
      .data_in(rd_data_in), .check_in(rd_check_in), .recomputed(gen_rd),
      .fix_en(fixing), .data_out(dec_data), .single(dec_single), .multi(dec_multi));

   always_comb begin
      unique case (mode)
         MODE_DETECT, MODE_CORRECT: wr_check = gen_wr;
         MODE_DIAG:                 wr_check = diag_chk;
         default:                   wr_check = '0;
      endcase
   end

   assign rd_data_out   = fixing ? dec_data : rd_data_in;
   assign rd_err_single = rd_valid && active && dec_single;
   assign rd_err_multi  = rd_valid && active && dec_multi;

   logic [N_IRQ-1:0] hits, ens, clrs, flags;
   assign hits = {rd_err_multi, rd_err_single};
   assign ens  = {multi_en, single_en};
   assign clrs = {irq_clr_multi, irq_clr_single};

   for (genvar i = 0; i < N_IRQ; i++) begin : g_irq
      ecc_irq_flag u_flag (
         .clk(clk), .rst_n(rst_n), .hit(hits[i]), .enable(ens[i]),
         .clr(clrs[i]), .flag(flags[i]));
   end

   assign irq_single = flags[0];
   assign irq_multi  = flags[1];

   AST_ONE_CLASS:    assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_err_single && rd_err_multi)); // R9
   AST_OFF_PASS:     assert property (@(posedge clk) disable iff (!rst_n)
      !active |-> (rd_data_out == rd_data_in) && !rd_err_single && !rd_err_multi); // R3
   AST_DETECT_NOFIX: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_DETECT || mode == MODE_DIAG) |-> rd_data_out == rd_data_in); // R7
   AST_MULTI_KEEP:   assert property (@(posedge clk) disable iff (!rst_n)
      rd_err_multi |-> rd_data_out == rd_data_in); // R9
   AST_RSVD_ZERO:    assert property (@(posedge clk) disable iff (!rst_n)
      $past(cfg_we) |-> cfg_rdata[7:5] == 3'b000 && cfg_rdata[31:16] == 16'h0); // R2
endmodule

// File: tb/ecc_mode_ctrl_tb.sv
`timescale 1ns/1ps
module ecc_mode_ctrl_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;
   logic [63:0] wr_data = '0;
   logic [7:0]  wr_check;
   logic        rd_valid = 1'b0;
   logic [63:0] rd_data_in = '0;
   logic [7:0]  rd_check_in = '0;
   logic [63:0] rd_data_out;
   logic        rd_err_single, rd_err_multi;
   logic        irq_clr_single = 1'b0, irq_clr_multi = 1'b0;
   logic        irq_single, irq_multi;

   int n_checks = 0;
   int n_fail   = 0;

   always #2.5 clk = ~clk;

   ecc_mode_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
      .cfg_rdata(cfg_rdata), .wr_data(wr_data), .wr_check(wr_check),
      .rd_valid(rd_valid), .rd_data_in(rd_data_in), .rd_check_in(rd_check_in),
      .rd_data_out(rd_data_out), .rd_err_single(rd_err_single),
      .rd_err_multi(rd_err_multi), .irq_clr_single(irq_clr_single),
      .irq_clr_multi(irq_clr_multi), .irq_single(irq_single), .irq_multi(irq_multi));

   function automatic logic [7:0] model_check(logic [63:0] d);
      logic [127:0] cw = '0;
      logic [7:0]   c  = '0;
      int           k  = 0;
      for (int p = 1; p < 72; p++)
         if ((p & (p - 1)) != 0) begin cw[p] = d[k]; k++; end
      for (int b = 0; b < 7; b++)
         for (int p = 1; p < 72; p++)
            if (((p >> b) & 1) == 1) c[b] = c[b] ^ cw[p];
      c[7] = (^d) ^ (^c[6:0]);
      return c;
   endfunction

   task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic set_reg(input logic [31:0] v);
      @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
      @(negedge clk); cfg_we = 1'b0;
   endtask

   task automatic do_read(input logic [63:0] d, input logic [7:0] c,
                          output logic [63:0] dout, output logic s, output logic m);
      @(negedge clk); rd_valid = 1'b1; rd_data_in = d; rd_check_in = c;
      #1; dout = rd_data_out; s = rd_err_single; m = rd_err_multi;
      @(posedge clk); #1; rd_valid = 1'b0;
   endtask

   task automatic t_reset;
      #1;
      check(cfg_rdata == 32'h0, "R1 reg", 64'(cfg_rdata), 64'h0);
      check(!irq_single && !irq_multi, "R1 irq", {62'h0, irq_multi, irq_single}, 64'h0);
      wr_data = 64'hDEAD_BEEF_0123_4567; #1;
      check(wr_check == 8'h0, "R1 wr_check", 64'(wr_check), 64'h0);
   endtask

   task automatic t_reg;
      set_reg(32'hFFFF_FFFF); #1;
      check(cfg_rdata == 32'h0000_FF1F, "R2 readback", 64'(cfg_rdata), 64'h0000_FF1F);
      set_reg(32'h1234_A5E9); #1;
      check(cfg_rdata == 32'h0000_A509, "R2 fields", 64'(cfg_rdata), 64'h0000_A509);
   endtask

   task automatic t_off(input logic [31:0] r, input string tag);
      logic [63:0] o; logic s, m;
      set_reg(r);
      wr_data = 64'h0F0F_1234_5678_9ABC; #1;
      check(wr_check == 8'h0, {tag, " wr_check"}, 64'(wr_check), 64'h0);
      do_read(64'h0000_0000_0000_0003, 8'h55, o, s, m);
      check(o == 64'h3 && !s && !m, {tag, " read"}, o, 64'h3);
   endtask

   task automatic t_encode;
      logic [63:0] pats [4] = '{64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0001, 64'hA5A5_3C3C_0F0F_9669};
      set_reg(32'h0000_0002);
      foreach (pats[i]) begin
         @(negedge clk); wr_data = pats[i]; #1;
         check(wr_check == model_check(pats[i]), "R4 encode", 64'(wr_check), 64'(model_check(pats[i])));
      end
      set_reg(32'h0000_0001);
      @(negedge clk); wr_data = pats[3]; #1;
      check(wr_check == model_check(pats[3]), "R4 encode detect", 64'(wr_check), 64'(model_check(pats[3])));
   endtask

   task automatic t_correct;
      logic [63:0] d = 64'h0123_4567_89AB_CDEF;
      logic [7:0]  c = model_check(d);
      logic [63:0] o; logic s, m;
      int          bits [4] = '{0, 17, 40, 63};
      set_reg(32'h0000_0002);
      do_read(d, c, o, s, m);
      check(o == d && !s && !m, "R6 clean", o, d);
      foreach (bits[i]) begin
         do_read(d ^ (64'h1 << bits[i]), c, o, s, m);
         check(o == d && s && !m, "R6 correct", o, d);
      end
      do_read(d, c ^ 8'h04, o, s, m);
      check(o == d && s && !m, "R8 check bit 2", o, d);
      do_read(d, c ^ 8'h80, o, s, m);
      check(o == d && s && !m, "R8 check bit 7", o, d);
      do_read(d ^ 64'h21, c, o, s, m);
      check(o == (d ^ 64'h21) && !s && m, "R9 double data", o, d ^ 64'h21);
      do_read(d ^ 64'h400, c ^ 8'h01, o, s, m);
      check(o == (d ^ 64'h400) && !s && m, "R9 data+check", o, d ^ 64'h400);
   endtask

   task automatic t_detect;
      logic [63:0] d = 64'hFEDC_BA98_7654_3210;
      logic [7:0]  c = model_check(d);
      logic [63:0] o; logic s, m;
      set_reg(32'h0000_0001);
      do_read(d ^ 64'h100, c, o, s, m);
      check(o == (d ^ 64'h100) && s && !m, "R7 detect nofix", o, d ^ 64'h100);
      set_reg(32'h0000_3C03); #1;
      wr_data = d; #1;
      check(wr_check == 8'h3C, "R5 diag check", 64'(wr_check), 64'h3C);
      do_read(d ^ 64'h2, c, o, s, m);
      check(o == (d ^ 64'h2) && s, "R7 diag nofix", o, d ^ 64'h2);
   endtask

   task automatic t_irq;
      logic [63:0] d = 64'h1111_2222_3333_4444;
      logic [7:0]  c = model_check(d);
      logic [63:0] o; logic s, m;
      set_reg(32'h0000_0002);
      do_read(d ^ 64'h8, c, o, s, m);
      do_read(d ^ 64'h3, c, o, s, m);
      check(!irq_single && !irq_multi, "R12 masked", {62'h0, irq_multi, irq_single}, 64'h0);
      set_reg(32'h0000_000A);
      do_read(d ^ 64'h8, c, o, s, m);
      check(irq_single && !irq_multi, "R10 single set", {62'h0, irq_multi, irq_single}, 64'h1);
      do_read(d, c, o, s, m);
      do_read(d, c, o, s, m);
      check(irq_single, "R10 sticky", 64'(irq_single), 64'h1);
      set_reg(32'h0000_001A);
      do_read(d ^ 64'h3, c, o, s, m);
      check(irq_multi, "R10 multi set", 64'(irq_multi), 64'h1);
      @(negedge clk); irq_clr_single = 1'b1;
      @(posedge clk); #1; irq_clr_single = 1'b0;
      check(!irq_single && irq_multi, "R11 clear single", {62'h0, irq_multi, irq_single}, 64'h2);
      @(negedge clk); irq_clr_multi = 1'b1; rd_valid = 1'b1; rd_data_in = d ^ 64'h3; rd_check_in = c;
      @(posedge clk); #1; irq_clr_multi = 1'b0; rd_valid = 1'b0;
      check(irq_multi, "R11 set wins", 64'(irq_multi), 64'h1);
      @(negedge clk); irq_clr_multi = 1'b1;
      @(posedge clk); #1; irq_clr_multi = 1'b0;
      check(!irq_multi, "R11 clear multi", 64'(irq_multi), 64'h0);
   endtask

   initial begin
      #(200000 * 5);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      t_reset;
      @(negedge clk); rst_n = 1'b1;
      t_reg;
      t_off(32'h0000_0000, "R3 off");
      t_off(32'h0000_0005, "R3 reserved mode");
      t_encode;
      t_correct;
      t_detect;
      t_irq;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule